// File: doc/BRIEF.md
# Baugh-Wooley Signed Array Multiplier

This block forms the product of two two's-complement operands of equal width (8 bits by default) without a behavioural multiply operator. Each operand bit is ANDed with each bit of the other operand. The terms that pair exactly one sign bit are inverted. A constant correction row is added, so that the unsigned-style array gives the signed result. The rows are compressed by levels of carry-save full adders into two vectors. A ripple adder built from explicit half and full adders then merges those two vectors.

The double-width result goes into a single output register with a synchronous active-high reset. It appears one clock edge after the operands are presented. The register is split into a low byte port and a high byte port. The block has no other state. It can take a new operand pair on every cycle.

Top module: `bw_mul_top`

## Requirements
- R1: For 8-bit operands `op_a` and `op_b` read as two's-complement, the 16-bit value `{prod_hi, prod_lo}` read as two's-complement equals the exact signed product.
- R2: `prod_lo` carries product bits 7:0 and `prod_hi` carries product bits 15:8, for example -3 × 100 = -300 gives `prod_hi` = 0xFE and `prod_lo` = 0xD4.
- R3: The product of operands that are present at a rising clock edge is visible on the outputs right after that edge, for example 20 × 30 = 600 (0x0258).
- R4: While `rst` is high at a rising edge, the registered product becomes 0 whatever the operands are. The first edge with `rst` low loads the product of the operands present at that edge.
- R5: When either operand is zero, the product is 0x0000.
- R6: The most negative operand is handled: -128 × -128 = 16384 (0x4000) and -128 × 127 = -16256 (0xC080).
- R7: A nonzero product has bit 15 equal to the XOR of the two operand sign bits (bit 7 of each), for example -1 × -1 = 1 and -5 × 7 = -35 (0xFFDD).
- R8: The block has no state other than the product. When the operands are held for several cycles, the outputs stay constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the product register |
| op_a | input | 8 | Multiplicand, two's-complement |
| op_b | input | 8 | Multiplier, two's-complement |
| prod_lo | output | 8 | Registered product bits 7:0 |
| prod_hi | output | 8 | Registered product bits 15:8 |

## Verification
Every one of the 65,536 operand pairs is applied on consecutive cycles, followed by random pairs. This sweep separates a wrong inversion of any single sign-paired term, and a misplaced correction bit, from a correct array, because each such fault affects only some column patterns. Directed pairs are also applied. The most-negative-operand pairs expose faults in the a7·b7 term and the column-15 constant. Zero operands show whether the correction row cancels completely. Mixed-sign pairs such as -3 × 100 check the byte split and the sign bit. Holding the operands for several cycles, and asserting reset with nonzero operands, show whether the register carries only the product.

// File: rtl/bw_mul_pkg.sv
package bw_mul_pkg;

   // rows left after one carry-save level: each group of three becomes two
   function automatic int csa_next_rows(input int n);
      return (n / 3) * 2 + (n % 3);
   endfunction

   // number of carry-save levels needed to bring n rows down to two
   function automatic int csa_level_count(input int n);
      int rows;
      int lvl;
      rows = n;
      lvl  = 0;
      while (rows > 2) begin
         rows = csa_next_rows(rows);
         lvl++;
      end
      return lvl;
   endfunction

   // rows present at the input of a given level
   function automatic int csa_rows_at(input int n, input int level);
      int rows;
      rows = n;
      for (int k = 0; k < level; k++) begin
         rows = csa_next_rows(rows);
      end
      return rows;
   endfunction

endpackage

// File: rtl/bw_fa.sv
module bw_fa (
   input  logic a,
   input  logic b,
   input  logic ci,
   output logic s,
   output logic co
);
   assign s  = a ^ b ^ ci;
   assign co = (a & b) | (a & ci) | (b & ci);
endmodule

// File: rtl/bw_ha.sv
module bw_ha (
   input  logic a,
   input  logic b,
   output logic s,
   output logic co
);
   assign s  = a ^ b;
   assign co = a & b;
endmodule

// File: rtl/bw_pp_rows.sv
module bw_pp_rows #(
   parameter int W = 8
) (
   input  logic [W-1:0]   mcand,
   input  logic [W-1:0]   mplier,
   output logic [2*W-1:0] rows [0:W]
);
   localparam int PW = 2 * W;

   // one row per multiplier bit, weighted by that bit's position
   for (genvar j = 0; j < W; j++) begin : g_row
      logic [W-1:0] term;
      for (genvar i = 0; i < W; i++) begin : g_bit
         localparam bit FLIP = (i == W - 1) ^ (j == W - 1);
         if (FLIP) begin : g_inv
            assign term[i] = ~(mcand[i] & mplier[j]);
         end else begin : g_pos
            assign term[i] = mcand[i] & mplier[j];
         end
      end
      assign rows[j] = PW'(term) << j;
   end

   // constant correction: one at column W and one at the top column
   localparam logic [PW-1:0] FIX = (PW'(1) << W) | (PW'(1) << (PW - 1));
   assign rows[W] = FIX;

endmodule

// File: rtl/bw_csa_tree.sv
module bw_csa_tree
   import bw_mul_pkg::*;
#(
   parameter int PW = 16,
   parameter int N  = 9
) (
   input  logic [PW-1:0] rin [0:N-1],
   output logic [PW-1:0] sum_row,
   output logic [PW-1:0] carry_row
);
   localparam int L = csa_level_count(N);

   logic [PW-1:0] lv [0:L][0:N-1];

   for (genvar r = 0; r < N; r++) begin : g_in
      assign lv[0][r] = rin[r];
   end

   for (genvar l = 0; l < L; l++) begin : g_lvl
      localparam int NIN  = csa_rows_at(N, l);
      localparam int NG   = NIN / 3;
      localparam int NOUT = csa_rows_at(N, l + 1);

      for (genvar g = 0; g < NG; g++) begin : g_grp
         assign lv[l+1][2*g+1][0] = 1'b0;
         for (genvar k = 0; k < PW; k++) begin : g_col
            if (k < PW - 1) begin : g_fa
               bw_fa u_fa (
                  .a  (lv[l][3*g][k]),
                  .b  (lv[l][3*g+1][k]),
                  .ci (lv[l][3*g+2][k]),
                  .s  (lv[l+1][2*g][k]),
                  .co (lv[l+1][2*g+1][k+1])
               );
            end else begin : g_top
               // carry out of the top column falls outside the result width
               assign lv[l+1][2*g][k] = lv[l][3*g][k] ^ lv[l][3*g+1][k] ^ lv[l][3*g+2][k];
            end
         end
      end

      for (genvar r = 3 * NG; r < NIN; r++) begin : g_pass
         assign lv[l+1][2*NG + r - 3*NG] = lv[l][r];
      end

      for (genvar r = NOUT; r < N; r++) begin : g_idle
         assign lv[l+1][r] = '0;
      end
   end

   assign sum_row   = lv[L][0];
   assign carry_row = lv[L][1];

endmodule

// File: rtl/bw_cpa.sv
module bw_cpa #(
   parameter int PW = 16
) (
   input  logic [PW-1:0] x,
   input  logic [PW-1:0] y,
   output logic [PW-1:0] s
);
   logic [PW-2:0] c;

   for (genvar k = 0; k < PW; k++) begin : g_bit
      if (k == 0) begin : g_lsb
         bw_ha u_ha (.a(x[0]), .b(y[0]), .s(s[0]), .co(c[0]));
      end else if (k < PW - 1) begin : g_mid
         bw_fa u_fa (.a(x[k]), .b(y[k]), .ci(c[k-1]), .s(s[k]), .co(c[k]));
      end else begin : g_msb
         assign s[k] = x[k] ^ y[k] ^ c[k-1];
      end
   end

endmodule

// File: rtl/bw_mul_top.sv
module bw_mul_top #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] op_a,
   input  logic [W-1:0] op_b,
   output logic [W-1:0] prod_lo,
   output logic [W-1:0] prod_hi
);
   localparam int PW = 2 * W;
   localparam int NR = W + 1;

   if (W < 2) begin : g_bad_width
      $error("bw_mul_top: operand width must be at least 2");
   end

   logic [PW-1:0] pp_rows [0:W];
   logic [PW-1:0] red_s;
   logic [PW-1:0] red_c;
   logic [PW-1:0] sum_w;
   logic [PW-1:0] prod_q;

   bw_pp_rows #(.W(W)) u_rows (
      .mcand  (op_a),
      .mplier (op_b),
      .rows   (pp_rows)
   );

   bw_csa_tree #(.PW(PW), .N(NR)) u_tree (
      .rin       (pp_rows),
      .sum_row   (red_s),
      .carry_row (red_c)
   );

   bw_cpa #(.PW(PW)) u_cpa (
      .x (red_s),
      .y (red_c),
      .s (sum_w)
   );

   always_ff @(posedge clk) begin
      if (rst) prod_q <= '0;
      else     prod_q <= sum_w;
   end

   assign prod_lo = prod_q[W-1:0];
   assign prod_hi = prod_q[PW-1:W];

   // ---------------- assertions ----------------
   logic signed [PW-1:0] a_ext;
   logic signed [PW-1:0] b_ext;
   assign a_ext = PW'($signed(op_a));
   assign b_ext = PW'($signed(op_b));

   assert_exact_product_R1: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> ($signed({prod_hi, prod_lo}) == $past(a_ext) * $past(b_ext)));

   assert_reset_clear_R4: assert property (@(posedge clk)
      rst |=> ({prod_hi, prod_lo} == '0));

   assert_zero_operand_R5: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && ($past(op_a) == '0 || $past(op_b) == '0)) |-> ({prod_hi, prod_lo} == '0));

   assert_sign_bit_R7: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(op_a) != '0 && $past(op_b) != '0)
      |-> (prod_hi[W-1] == ($past(op_a[W-1]) ^ $past(op_b[W-1]))));

   assert_hold_stable_R8: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $stable(op_a) && $stable(op_b)) |=> $stable({prod_hi, prod_lo}));

endmodule

// File: tb/tb_bw_mul_top.sv
`timescale 1ns/1ps
module tb_bw_mul_top;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] a   = 8'd5;
   logic [7:0] b   = 8'd7;
   logic [7:0] lo;
   logic [7:0] hi;

   int    n_chk  = 0;
   int    n_fail = 0;
   bit    en     = 1'b0;
   bit    done   = 1'b0;
   string tag    = "R4";
   logic [15:0] model_q;

   bw_mul_top #(.W(8)) dut (
      .clk(clk), .rst(rst), .op_a(a), .op_b(b), .prod_lo(lo), .prod_hi(hi)
   );

   always #4 clk = ~clk;

   function automatic logic [15:0] ref_mul(input logic [7:0] x, input logic [7:0] y);
      int p;
      p = int'($signed(x)) * int'($signed(y));
      return p[15:0];
   endfunction

   task automatic check16(input string r, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h (a=%0d b=%0d)", r, act, exp,
                  $signed(a), $signed(b));
      end
   endtask

   task automatic check8(input string r, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", r, act, exp);
      end
   endtask

   // behavioural model of the output register
   always @(posedge clk) begin
      model_q <= rst ? 16'h0000 : ref_mul(a, b);
   end

   // compare on every cycle, away from the active edge
   always @(negedge clk) begin
      if (en && !done) check16(tag, {hi, lo}, model_q);
   end

   task automatic drive(input logic [7:0] x, input logic [7:0] y);
      @(negedge clk);
      a = x;
      b = y;
   endtask

   task automatic apply_check(input string r, input logic [7:0] x, input logic [7:0] y,
                              input logic [15:0] exp);
      tag = r;
      drive(x, y);
      @(negedge clk);
      check16(r, {hi, lo}, exp);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      en = 1'b1;
      check16("R4", {hi, lo}, 16'h0000);          // reset with nonzero operands
      rst = 1'b0;
      tag = "R3";
      @(negedge clk);
      check16("R3", {hi, lo}, 16'd35);            // 5 x 7 after one edge

      apply_check("R3", 8'd20, 8'd30, 16'h0258);
      apply_check("R1", 8'd20, 8'd30, 16'd600);
      apply_check("R6", 8'h80, 8'h80, 16'h4000);
      apply_check("R6", 8'h80, 8'h7F, 16'hC080);
      apply_check("R7", 8'hFF, 8'hFF, 16'h0001);
      apply_check("R7", 8'hFB, 8'd7,  16'hFFDD);
      apply_check("R5", 8'h00, 8'h80, 16'h0000);
      apply_check("R5", 8'd77, 8'h00, 16'h0000);

      tag = "R2";
      drive(8'hFD, 8'd100);
      @(negedge clk);
      check8("R2", lo, 8'hD4);
      check8("R2", hi, 8'hFE);

      tag = "R8";
      drive(8'h9C, 8'd99);                          // -100 x 99 = -9900
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         check16("R8", {hi, lo}, 16'hD954);
      end

      tag = "R4";
      drive(8'd50, 8'd50);
      rst = 1'b1;
      for (int k = 0; k < 2; k++) begin
         @(negedge clk);
         check16("R4", {hi, lo}, 16'h0000);
      end
      rst = 1'b0;
      @(negedge clk);
      check16("R4", {hi, lo}, 16'h09C4);

      tag = "R1";
      for (int i = 0; i < 256; i++) begin
         for (int j = 0; j < 256; j++) begin
            drive(8'(i), 8'(j));
         end
      end
      for (int k = 0; k < 300; k++) begin
         drive(8'($urandom), 8'($urandom));
      end
      @(negedge clk);
      @(negedge clk);
      finish_run();
   end

   initial begin
      #(8 * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

endmodule